// File: doc/BRIEF.md
# Indexed USB Endpoint Control Bank

This block keeps the control byte of each of four USB function endpoints and decides, for every token the serial engine reports, which handshake the addressed endpoint returns. Software reaches all four control bytes through one register window. A small index register picks which endpoint's byte the window reads and writes. The same byte can then serve any endpoint without spending extra address space.

Each token event carries an endpoint number, a token kind, a buffer-ready flag and a pending-setup flag. The block registers a one-hot handshake code one clock later: silence, ACK, NAK or STALL. Only some endpoints can use the dual-buffer and isochronous options. The stored bits are also exported as a flat configuration bus, which the FIFO logic outside this block uses.

Top module: `usb_ep_ctl_bank`

## Requirements
- R1: The index register is 2 bits wide and resets to 0. A CPU write with `cpu_sel`=0 loads `cpu_wdata[1:0]`, and a read with `cpu_sel`=0 returns the index with bits 7..2 at 0.
- R2: A CPU write with `cpu_sel`=1 updates only the control byte of the indexed endpoint, and a read with `cpu_sel`=1 returns that byte. The other endpoints keep their values.
- R3: After reset, endpoint 0 holds 0x05 (receive and transmit enabled) and endpoints 1 to 3 hold 0x00. `ep_cfg` byte e (bits 8e+7..8e) shows endpoint e.
- R4: The control byte fields are: bit7 rx stall, bit6 tx stall, bit5 rx dual buffer, bit4 tx dual buffer, bit3 rx isochronous, bit2 rx enable, bit1 tx isochronous, bit0 tx enable. Bits 5 and 3 are kept only on endpoint 3, and bits 4 and 1 only on endpoint 2. On the other endpoints, writes to these bits are ignored and the bits read as 0, so writing 0xFF reads back 0xC5, 0xC5, 0xD7 and 0xED for endpoints 0 to 3.
- R5: `hs_code` is one-hot, with bit0 none, bit1 ACK, bit2 NAK and bit3 STALL. It is registered and valid together with `hs_valid` one clock after `tok_valid`. In cycles without a token it shows none, with `hs_valid` low. The `tok_kind` codes are 0 OUT, 1 IN, 2 SETUP and 3 reserved, and the reserved code always gives none.
- R6: An OUT or SETUP token to an endpoint whose rx enable is clear gives none. An IN token to an endpoint whose tx enable is clear gives none.
- R7: An OUT token to an endpoint with rx enabled and rx stall set gives STALL, unless `rx_setup_pend` is high. A SETUP token to an endpoint with rx enabled always gives ACK, whatever the stall and ready state.
- R8: An IN token to an enabled, non-isochronous endpoint with tx stall set gives STALL. The tx stall has no effect on OUT tokens.
- R9: An OUT or IN token to an enabled, non-isochronous endpoint that is not stalled gives ACK when `tok_ready` is high and NAK when it is low.
- R10: An isochronous direction (rx on endpoint 3, tx on endpoint 2) answers enabled tokens of that direction with none, even when its stall bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_sel | input | 1 | 0 selects the index register, 1 selects the control window |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data of the selected register (combinational) |
| tok_valid | input | 1 | Token event strobe |
| tok_ep | input | 2 | Endpoint addressed by the token |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| tok_ready | input | 1 | Endpoint buffer can accept or supply data |
| rx_setup_pend | input | 1 | Receive-setup flag that lifts the rx stall |
| hs_valid | output | 1 | Decision valid, one clock after tok_valid |
| hs_code | output | 4 | One-hot handshake: none, ACK, NAK, STALL |
| ep_cfg | output | 32 | Stored control bytes, endpoint e in byte e |

## Verification
The decision logic is tried with a table of token patterns. Each pattern pairs one control byte with a token kind and the ready and setup-pending flags, and each one isolates a single rule. Examples are stall against setup, stall against pending setup, ready against not ready, isochronous against stall, and a feature bit set on an endpoint that cannot hold it. Register access is tried with all-ones writes on every endpoint, which exposes the per-endpoint feature masks. Writes made through one index are then checked to leave the other endpoints untouched. Reset values, index truncation and idle cycles are checked directly.

// File: rtl/usb_epc_pkg.sv
// Shared types for the endpoint control bank.
// Assumes: the control byte is the packed struct below, MSB first.
package usb_epc_pkg;
    typedef enum logic [1:0] {
        TK_OUT   = 2'b00,
        TK_IN    = 2'b01,
        TK_SETUP = 2'b10,
        TK_RSVD  = 2'b11
    } tok_kind_e;

    typedef enum logic [3:0] {
        HS_NONE  = 4'b0001,
        HS_ACK   = 4'b0010,
        HS_NAK   = 4'b0100,
        HS_STALL = 4'b1000
    } hs_e;

    typedef struct packed {
        logic rx_stl;
        logic tx_stl;
        logic rx_dbuf;
        logic tx_dbuf;
        logic rx_iso;
        logic rx_en;
        logic tx_iso;
        logic tx_en;
    } ep_ctl_t;

    localparam logic [7:0] MASK_BASE = 8'b1100_0101;
    localparam logic [7:0] MASK_RXF  = 8'b0010_1000;
    localparam logic [7:0] MASK_TXF  = 8'b0001_0010;
    localparam logic [7:0] EP0_RST   = 8'b0000_0101;
endpackage

// File: rtl/usb_epc_index.sv
// Index register that steers the control window to one endpoint.
// Assumes: wr_en is already qualified with the index address.
module usb_epc_index #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wdata,
    output logic [IDX_W-1:0] idx
);
    // Hold the selected endpoint number; reset selects endpoint 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (wr_en) idx <= wdata;
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(idx)); // R1
endmodule

// File: rtl/usb_epc_reg.sv
// One endpoint's control byte. Only bits set in WMASK get a flop;
// the other bits are tied to 0, so writes to them are lost.
// Assumes: wr_en is already qualified with the window address and index.
module usb_epc_reg
    import usb_epc_pkg::*;
#(
    parameter logic [7:0] WMASK   = MASK_BASE,
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output ep_ctl_t    ctl
);
    logic [7:0] bits_q;

    // One flop per kept bit; unkept bits are constant 0.
    for (genvar b = 0; b < 8; b++) begin : g_bit
        if (WMASK[b]) begin : g_kept
            // Store one kept control bit.
            always_ff @(posedge clk) begin
                if (!rst_n)     bits_q[b] <= RST_VAL[b];
                else if (wr_en) bits_q[b] <= wdata[b];
            end
        end else begin : g_tied
            assign bits_q[b] = 1'b0;
        end
    end

    assign ctl = ep_ctl_t'(bits_q);

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl)); // R2
endmodule

// File: rtl/usb_epc_decide.sv
// Registered handshake decision for one token event.
// Assumes: per-endpoint flag vectors already carry the feature masking.
module usb_epc_decide
    import usb_epc_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] rx_en,
    input  logic [NUM_EP-1:0] rx_stl,
    input  logic [NUM_EP-1:0] rx_iso,
    input  logic [NUM_EP-1:0] tx_en,
    input  logic [NUM_EP-1:0] tx_stl,
    input  logic [NUM_EP-1:0] tx_iso,
    input  logic              tok_valid,
    input  logic [IDX_W-1:0]  tok_ep,
    input  logic [1:0]        tok_kind,
    input  logic              tok_ready,
    input  logic              rx_setup_pend,
    output logic              hs_valid,
    output logic [3:0]        hs_code
);
    hs_e hs_d;

    // Choose the handshake from the addressed endpoint's flags.
    always_comb begin
        hs_d = HS_NONE;
        case (tok_kind_e'(tok_kind))
            TK_OUT: begin
                if (!rx_en[tok_ep] || rx_iso[tok_ep])       hs_d = HS_NONE;
                else if (rx_stl[tok_ep] && !rx_setup_pend) hs_d = HS_STALL;
                else                                       hs_d = tok_ready ? HS_ACK : HS_NAK;
            end
            TK_SETUP: begin
                hs_d = rx_en[tok_ep] ? HS_ACK : HS_NONE;
            end
            TK_IN: begin
                if (!tx_en[tok_ep] || tx_iso[tok_ep]) hs_d = HS_NONE;
                else if (tx_stl[tok_ep])             hs_d = HS_STALL;
                else                                 hs_d = tok_ready ? HS_ACK : HS_NAK;
            end
            default: hs_d = HS_NONE;
        endcase
    end

    // Register the decision; idle cycles show none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= tok_valid;
            hs_code  <= tok_valid ? hs_d : HS_NONE;
        end
    end

    AST_HS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hs_code) == 1); // R5
    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> (hs_code == HS_NONE && !hs_valid)); // R5
    AST_RX_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind != TK_IN && !rx_en[tok_ep] |=> hs_code == HS_NONE); // R6
    AST_TX_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_IN && !tx_en[tok_ep] |=> hs_code == HS_NONE); // R6
    AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_SETUP && rx_en[tok_ep] |=> hs_code == HS_ACK); // R7
    AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_IN && tx_en[tok_ep] && !tx_iso[tok_ep]
        && tx_stl[tok_ep] |=> hs_code == HS_STALL); // R8
    AST_ISO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_IN && tx_iso[tok_ep] |=> hs_code == HS_NONE); // R10
endmodule

// File: rtl/usb_ep_ctl_bank.sv
// Top of the endpoint control bank: index register, one control byte
// per endpoint behind a shared window, and the handshake decision.
// Assumes: NUM_EP equals 2**IDX_W; feature endpoints are below NUM_EP.
module usb_ep_ctl_bank
    import usb_epc_pkg::*;
#(
    parameter int NUM_EP     = 4,
    parameter int RX_FEAT_EP = 3,
    parameter int TX_FEAT_EP = 2,
    localparam int IDX_W     = $clog2(NUM_EP),
    localparam int CFG_W     = NUM_EP * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_sel,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic             tok_valid,
    input  logic [IDX_W-1:0] tok_ep,
    input  logic [1:0]       tok_kind,
    input  logic             tok_ready,
    input  logic             rx_setup_pend,
    output logic             hs_valid,
    output logic [3:0]       hs_code,
    output logic [CFG_W-1:0] ep_cfg
);
    logic [IDX_W-1:0]  idx;
    ep_ctl_t           ctl [NUM_EP];
    logic [NUM_EP-1:0] rx_en, rx_stl, rx_iso, tx_en, tx_stl, tx_iso;

    usb_epc_index #(.IDX_W(IDX_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr && !cpu_sel),
        .wdata (cpu_wdata[IDX_W-1:0]),
        .idx   (idx)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        localparam logic [7:0] MASK_E = MASK_BASE
            | ((e == RX_FEAT_EP) ? MASK_RXF : 8'h00)
            | ((e == TX_FEAT_EP) ? MASK_TXF : 8'h00);
        localparam logic [7:0] RST_E = (e == 0) ? EP0_RST : 8'h00;

        usb_epc_reg #(.WMASK(MASK_E), .RST_VAL(RST_E)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (cpu_wr && cpu_sel && (idx == IDX_W'(e))),
            .wdata (cpu_wdata),
            .ctl   (ctl[e])
        );

        assign rx_en[e]  = ctl[e].rx_en;
        assign rx_stl[e] = ctl[e].rx_stl;
        assign rx_iso[e] = ctl[e].rx_iso;
        assign tx_en[e]  = ctl[e].tx_en;
        assign tx_stl[e] = ctl[e].tx_stl;
        assign tx_iso[e] = ctl[e].tx_iso;
        assign ep_cfg[e*8 +: 8] = ctl[e];

        AST_FEAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (ep_cfg[e*8 +: 8] & ~MASK_E) == 8'h00); // R4
    end

    // CPU read mux: index with zero upper bits, or the indexed byte.
    always_comb begin
        if (cpu_sel) cpu_rdata = ctl[idx];
        else         cpu_rdata = {{(8 - IDX_W){1'b0}}, idx};
    end

    usb_epc_decide #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_decide (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .rx_stl        (rx_stl),
        .rx_iso        (rx_iso),
        .tx_en         (tx_en),
        .tx_stl        (tx_stl),
        .tx_iso        (tx_iso),
        .tok_valid     (tok_valid),
        .tok_ep        (tok_ep),
        .tok_kind      (tok_kind),
        .tok_ready     (tok_ready),
        .rx_setup_pend (rx_setup_pend),
        .hs_valid      (hs_valid),
        .hs_code       (hs_code)
    );

    AST_IDX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sel |-> cpu_rdata[7:IDX_W] == '0); // R1
endmodule

// File: tb/usb_ep_ctl_bank_test.sv
`timescale 1ns/1ps
// Self-checking bench: vector table for token decisions, then
// directed checks for reset, masking, index width and isolation.
module usb_ep_ctl_bank_test;
    localparam logic [1:0] KO = 2'b00, KI = 2'b01, KS = 2'b10, KR = 2'b11;
    localparam logic [3:0] HN = 4'b0001, HA = 4'b0010, HK = 4'b0100, HS = 4'b1000;
    localparam int NV = 17;
    // layout: [17:16] ep, [15:8] ctl, [7:6] kind, [5] ready, [4] pend, [3:0] expected
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h05, KO, 1'b1, 1'b0, HA},  // R9 ready
        {2'd0, 8'h05, KO, 1'b0, 1'b0, HK},  // R9 not ready
        {2'd0, 8'h85, KO, 1'b1, 1'b0, HS},  // R7 rx stall
        {2'd0, 8'h85, KO, 1'b1, 1'b1, HA},  // R7 pending setup lifts stall
        {2'd0, 8'h85, KS, 1'b0, 1'b0, HA},  // R7 setup overrides stall
        {2'd0, 8'h04, KI, 1'b1, 1'b0, HN},  // R6 tx disabled
        {2'd0, 8'h01, KO, 1'b1, 1'b0, HN},  // R6 rx disabled OUT
        {2'd0, 8'h01, KS, 1'b1, 1'b0, HN},  // R6 rx disabled SETUP
        {2'd1, 8'h41, KI, 1'b1, 1'b0, HS},  // R8 tx stall
        {2'd1, 8'h01, KI, 1'b0, 1'b0, HK},  // R9 IN not ready
        {2'd1, 8'h45, KO, 1'b1, 1'b0, HA},  // R8 tx stall leaves OUT alone
        {2'd2, 8'h03, KI, 1'b1, 1'b0, HN},  // R10 tx iso
        {2'd2, 8'h43, KI, 1'b1, 1'b0, HN},  // R10 iso beats stall
        {2'd1, 8'h03, KI, 1'b1, 1'b0, HA},  // R4 iso bit not kept on ep1
        {2'd3, 8'h0C, KO, 1'b1, 1'b0, HN},  // R10 rx iso
        {2'd2, 8'h0C, KO, 1'b1, 1'b0, HA},  // R4 rx iso not kept on ep2
        {2'd3, 8'h05, KR, 1'b1, 1'b0, HN}   // R5 reserved kind
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_sel = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        tok_valid = 1'b0;
    logic [1:0]  tok_ep = '0, tok_kind = '0;
    logic        tok_ready = 1'b0, rx_setup_pend = 1'b0;
    logic        hs_valid;
    logic [3:0]  hs_code;
    logic [31:0] ep_cfg;
    int total = 0, bad = 0, cycles = 0;

    always #2.5 clk = ~clk;

    usb_ep_ctl_bank uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
        .tok_ep(tok_ep), .tok_kind(tok_kind), .tok_ready(tok_ready),
        .rx_setup_pend(rx_setup_pend), .hs_valid(hs_valid), .hs_code(hs_code),
        .ep_cfg(ep_cfg)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_sel = sel;
        #1;
        check(req, {24'h0, cpu_rdata}, {24'h0, exp});
    endtask

    task automatic token(input logic [1:0] ep, input logic [1:0] k, input logic rdy,
                         input logic pend, input logic [3:0] exp, input string req);
        @(negedge clk);
        tok_valid = 1'b1; tok_ep = ep; tok_kind = k; tok_ready = rdy; rx_setup_pend = pend;
        @(negedge clk);
        tok_valid = 1'b0;
        check(req, {27'h0, hs_valid, hs_code}, {27'h0, 1'b1, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 and R1 reset state
        cpu_read(1'b0, 8'h00, "R1 index after reset");
        check("R3 ep_cfg after reset", ep_cfg, 32'h0000_0005);
        cpu_read(1'b1, 8'h05, "R3 ep0 window after reset");
        check("R5 idle output", {27'h0, hs_valid, hs_code}, {27'h0, 1'b0, HN});

        // Decision table (R5 to R10)
        for (int i = 0; i < NV; i++) begin
            cpu_write(1'b0, {6'h0, VEC[i][17:16]});
            cpu_write(1'b1, VEC[i][15:8]);
            token(VEC[i][17:16], VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3:0],
                  $sformatf("decision vector %0d", i));
        end
        @(negedge clk);
        check("R5 idle after token", {27'h0, hs_valid, hs_code}, {27'h0, 1'b0, HN});

        // R4 feature masks with all-ones writes
        for (int e = 0; e < 4; e++) begin
            cpu_write(1'b0, 8'(e));
            cpu_write(1'b1, 8'hFF);
        end
        check("R4 masks on ep_cfg", ep_cfg, 32'hED_D7_C5_C5);
        cpu_write(1'b0, 8'h03);
        cpu_read(1'b1, 8'hED, "R4 ep3 readback");
        cpu_write(1'b0, 8'h02);
        cpu_read(1'b1, 8'hD7, "R4 ep2 readback");

        // R2 isolation: clear ep1 only
        cpu_write(1'b0, 8'h01);
        cpu_write(1'b1, 8'h00);
        check("R2 other endpoints unchanged", ep_cfg, 32'hED_D7_00_C5);
        cpu_read(1'b1, 8'h00, "R2 ep1 window");

        // R1 index truncation
        cpu_write(1'b0, 8'hFF);
        cpu_read(1'b0, 8'h03, "R1 index upper bits");
        cpu_read(1'b1, 8'hED, "R1 index 3 selects ep3");

        // R3 reset restores values
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R3 ep_cfg after second reset", ep_cfg, 32'h0000_0005);
        cpu_read(1'b0, 8'h00, "R1 index after second reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule